// File: doc/BRIEF.md
# Dual-Bank Memory with Single-Cycle Clear

This block presents one simple RAM to its user: a write port, a read port with one clock of latency, and a clear request. A clear takes effect at once, so every location reads zero from the next cycle on. Internally it holds two full-depth banks. One bank is active and serves all traffic. The other bank is a spare that has already been zeroed. A clear just swaps the two roles. A sequencer then zeroes the bank that was just released, one location per clock, while normal traffic continues on the new active bank.

Each clear leaves the spare dirty until the sequencer has finished with it, so the block shows whether another clear can be taken. When the `clr_ready` output is high, a request is accepted. When it is low, the request has no effect and the block raises a one-cycle error flag. After reset the block zeroes both banks in parallel, which takes DEPTH cycles. During that time it accepts no clear and ignores writes. Bank 0 is then active.

Top module: `pingpong_clear_ram`

## Requirements
- R1: While reset is held, `clr_ready` and `clr_err` are low. After reset is released, `clr_ready` stays low for DEPTH rising edges and is high after the DEPTH-th edge.
- R2: After initialization, every location reads zero.
- R3: Read data is valid one cycle after the read address is sampled, at the next rising edge. If a write to the same location happens at that edge, the newly written value is returned.
- R4: A clear is accepted when `clr_req` is high at an edge where `clr_ready` is high. From the next cycle on, all locations that were written before the request read zero.
- R5: After an accepted clear, `clr_ready` is low from the next cycle. It becomes high again after exactly DEPTH edges counted from the accepting edge, including that edge. Two clears can therefore be accepted DEPTH cycles apart.
- R6: A clear request sampled while `clr_ready` is low does not change the stored contents. It causes `clr_err` to be high for exactly the following cycle.
- R7: A write at the same edge as an accepted clear lands in the newly active bank and can be read back after the clear.
- R8: Writes made during the post-reset initialization are dropped. The location reads zero afterwards.
- R9: Data left in a bank when a clear releases it does not return when a later clear makes that bank active again. The bank reads all zeros.
- R10: Writes made while the background clear is running are kept intact. The sequencer never touches the active bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | $clog2(DEPTH) | Write location |
| wr_data | input | DWIDTH | Write value |
| rd_addr | input | $clog2(DEPTH) | Read location, registered inside |
| rd_data | output | DWIDTH | Contents at the registered read location in the active bank |
| clr_req | input | 1 | Request a clear of all contents |
| clr_ready | output | 1 | High when a clear request would be accepted |
| clr_err | output | 1 | One-cycle flag for a rejected clear request |

## Verification
Some internal faults show up quickly at the ports:
- A wrong bank select appears one cycle after a clear, as stale data read back instead of zero, or as a lost write.
- A miscounting sequencer shows up as `clr_ready` rising too early or too late. The bench checks this to the exact edge.
- A sequencer that stops early leaves dirty words in the spare bank. These are only seen after the next swap, when stale data reappears.
- A sequencer that writes into the wrong bank erases data written during the clear window. This is seen at the next read of that location.

The bench therefore reads back across two further swaps, not only the first one.

// File: rtl/pingpong_clear_ram.sv
module pingpong_clear_ram #(
  parameter int DWIDTH = 16,
  parameter int DEPTH  = 1024
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   wr_en,
  input  logic [((DEPTH>1)?$clog2(DEPTH):1)-1:0] wr_addr,
  input  logic [DWIDTH-1:0]                      wr_data,
  input  logic [((DEPTH>1)?$clog2(DEPTH):1)-1:0] rd_addr,
  output logic [DWIDTH-1:0]                      rd_data,
  input  logic                                   clr_req,
  output logic                                   clr_ready,
  output logic                                   clr_err
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DWIDTH-1:0] mem [2][DEPTH];
  logic          active, init, busy;
  logic [AW-1:0] cnt, rd_q;

  wire           accept  = clr_req & clr_ready;
  wire           wr_bank = active ^ accept;
  wire           cl_bank = accept ? active : ~active;
  wire [AW-1:0]  cl_addr = accept ? '0 : cnt;
  wire           cl_en   = accept | busy;

  assign clr_ready = ~init & ~busy;
  assign rd_data   = mem[active][rd_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      init    <= 1'b1;
      busy    <= 1'b0;
      cnt     <= '0;
      rd_q    <= '0;
      clr_err <= 1'b0;
    end else begin
      rd_q    <= rd_addr;
      clr_err <= clr_req & ~clr_ready;
      if (init) begin
        cnt <= cnt + 1'b1;
        if (cnt == LAST) begin
          init <= 1'b0;
          cnt  <= '0;
        end
      end else if (accept) begin
        active <= ~active;
        if (DEPTH > 1) begin
          busy <= 1'b1;
          cnt  <= AW'(1);
        end
      end else if (busy) begin
        cnt <= cnt + 1'b1;
        if (cnt == LAST) begin
          busy <= 1'b0;
          cnt  <= '0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (init) begin
      mem[0][cnt] <= '0;
      mem[1][cnt] <= '0;
    end else begin
      if (cl_en) mem[cl_bank][cl_addr] <= '0;
      if (wr_en) mem[wr_bank][wr_addr] <= wr_data;
    end
  end

  p_accept_drops_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && DEPTH > 1) |=> !clr_ready);

  p_ready_after_full_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clr_ready) |-> $past(cnt) == LAST);

  p_reject_flagged_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !clr_ready) |=> clr_err);

  p_err_has_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_err |-> $past(clr_req && !clr_ready));

  p_bank_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(active));
endmodule

// File: tb/tb_pingpong_clear_ram.sv
module tb_pingpong_clear_ram;
  localparam int DW = 16;
  localparam int DEPTH = 16;
  localparam int AW = $clog2(DEPTH);

  logic clk = 0, rst_n = 0, wr_en = 0, clr_req = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0, rd_data;
  logic clr_ready, clr_err;
  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pingpong_clear_ram #(.DWIDTH(DW), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .clr_req(clr_req),
    .clr_ready(clr_ready), .clr_err(clr_err));

  task automatic step(); @(negedge clk); endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [AW-1:0] a, logic [DW-1:0] d);
    wr_en = 1; wr_addr = a; wr_data = d; step(); wr_en = 0;
  endtask

  task automatic read_check(string req, logic [AW-1:0] a, logic [DW-1:0] exp);
    rd_addr = a; step(); check(req, rd_data, exp);
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 4*DEPTH && !clr_ready; i++) step();
  endtask

  task automatic t_reset_init();
    step(); step();
    check("R1 ready in reset", clr_ready, 0);
    check("R1 err in reset", clr_err, 0);
    rst_n = 1;
    do_write(3, 16'hBEEF);
    repeat (DEPTH-2) step();
    check("R1 ready before DEPTH edges", clr_ready, 0);
    step();
    check("R1 ready after DEPTH edges", clr_ready, 1);
    read_check("R8 init write dropped", 3, 0);
    read_check("R2 zero addr0", 0, 0);
    read_check("R2 zero last", DEPTH-1, 0);
  endtask

  task automatic t_write_read();
    do_write(1, 16'h1111);
    do_write(2, 16'h2222);
    read_check("R3 readback a1", 1, 16'h1111);
    read_check("R3 readback a2", 2, 16'h2222);
    rd_addr = 9; wr_en = 1; wr_addr = 9; wr_data = 16'h1234; step(); wr_en = 0;
    check("R3 same-edge write", rd_data, 16'h1234);
  endtask

  task automatic t_clear_swap();
    clr_req = 1; wr_en = 1; wr_addr = 5; wr_data = 16'h5A5A;
    step(); clr_req = 0; wr_en = 0;
    check("R5 ready drops", clr_ready, 0);
    check("R6 no err on accept", clr_err, 0);
    repeat (DEPTH-2) step();
    check("R5 ready still low", clr_ready, 0);
    step();
    check("R5 ready after DEPTH", clr_ready, 1);
    read_check("R7 write with clear", 5, 16'h5A5A);
    read_check("R4 old a1 cleared", 1, 0);
    read_check("R4 old a2 cleared", 2, 0);
    read_check("R4 old a9 cleared", 9, 0);
  endtask

  task automatic t_reject_and_return();
    clr_req = 1; step(); clr_req = 0;
    do_write(7, 16'h7777);
    clr_req = 1; step(); clr_req = 0;
    check("R6 err pulse", clr_err, 1);
    step();
    check("R6 err one cycle", clr_err, 0);
    read_check("R10 write during clear kept", 7, 16'h7777);
    read_check("R9 bank0 old a1 gone", 1, 0);
    read_check("R6 bank unchanged", 5, 0);
    wait_ready();
    check("R5 ready returns", clr_ready, 1);
    read_check("R10 still kept", 7, 16'h7777);
    clr_req = 1; step(); clr_req = 0;
    read_check("R9 bank1 a5 gone", 5, 0);
    wait_ready();
    clr_req = 1; step(); clr_req = 0;
    read_check("R9 bank0 a7 gone", 7, 0);
  endtask

  initial begin
    t_reset_init();
    t_write_read();
    t_clear_swap();
    t_reject_and_return();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule